// File: doc/BRIEF.md
# Mode-Aliased Floating-Point Register File

This block holds the floating-point general registers of a processor: 32 entries of 64 bits. Each entry can be reached as its low 32-bit half, its high 32-bit half, or as a whole 64-bit value. A mode input selects how register numbers map onto that storage. In wide mode every number names its own 64-bit entry. In narrow mode the file behaves as sixteen 64-bit pairs. A 32-bit access to an odd number lands in the upper half of the even entry below it, and a 64-bit access ignores the lowest index bit.

There is one combinational read port and one write port that updates on the clock edge. Each port has a 5-bit index and a single/double size select. A coprocessor-usable input gates every access. When it is low, a requested access does nothing, and the block raises a coprocessor-unusable fault that carries coprocessor number 1.

Top module: `fpr_file`

## Requirements
- R1: After reset every entry holds zero; all 64-bit reads in wide mode return 0.
- R2: In wide mode (wide_i=1), a 32-bit access to index n reads or writes bits [31:0] of entry n.
- R3: In narrow mode (wide_i=0), a 32-bit access to an odd index n reads or writes bits [63:32] of entry n-1.
- R4: In narrow mode, a 32-bit access to an even index n reads or writes bits [31:0] of entry n.
- R5: A 64-bit access (dbl=1) uses entry n with bit 0 cleared in narrow mode, and uses entry n unchanged in wide mode.
- R6: While cu_ok_i is 0, a requested read or write is not performed: storage is unchanged, rd_data_o is 0, cu_fault_o is 1 and cu_num_o is 1.
- R7: A 32-bit write changes only the selected half; the other half of that entry keeps its value.
- R8: A 32-bit read returns its 32-bit value in rd_data_o[31:0], with rd_data_o[63:32] zero.
- R9: The read is combinational and a write takes effect at the rising clock edge. A read of the storage being written in the same cycle returns the old value.
- R10: With no access requested, or with cu_ok_i high, cu_fault_o is 0 and cu_num_o is 0. With rd_en_i low, rd_data_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wide_i | input | 1 | 1: 32 independent 64-bit entries; 0: paired aliasing |
| cu_ok_i | input | 1 | Coprocessor usable; gates every access |
| rd_en_i | input | 1 | Read request |
| rd_idx_i | input | 5 | Read register number |
| rd_dbl_i | input | 1 | Read size: 1 = 64-bit, 0 = 32-bit |
| rd_data_o | output | 64 | Read data, zero-extended for 32-bit reads |
| wr_en_i | input | 1 | Write request |
| wr_idx_i | input | 5 | Write register number |
| wr_dbl_i | input | 1 | Write size: 1 = 64-bit, 0 = 32-bit |
| wr_data_i | input | 64 | Write data; 32-bit writes use bits [31:0] |
| cu_fault_o | output | 1 | Coprocessor-unusable fault for the current request |
| cu_num_o | output | 2 | Coprocessor number of the fault (1), else 0 |

## Verification
The directed cases write 32-bit values to odd and even indices in narrow mode. They then read back the whole entry in wide mode, which separates a correct high-half alias from a low-half or wrong-entry write. Other directed cases cover a 64-bit access to an odd index in both modes, a same-cycle read and write of one entry, and requests made while the coprocessor is unusable. A long random run draws the mode, the sizes, the indices, the data and the usable bit. It mixes the two views of one storage, so that any stray half-write or a wrong index mapping appears on later reads.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  // Which halves of an entry an access touches
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2,
    SEL_BOTH = 2'd3
  } half_sel_e;

  localparam logic [1:0] CU_NUM_FPU = 2'd1;
endpackage

// File: rtl/fpr_addr_map.sv
module fpr_addr_map
  import fpr_pkg::*;
#(
  parameter int unsigned IDXW = 5
) (
  input  logic [IDXW-1:0] idx_i,
  input  logic            dbl_i,
  input  logic            wide_i,
  input  logic            act_i,
  output logic [IDXW-1:0] row_o,
  output half_sel_e       sel_o
);
  always_comb begin
    row_o = idx_i;
    sel_o = SEL_NONE;
    if (act_i) begin
      if (dbl_i) begin
        sel_o = SEL_BOTH;
        if (!wide_i) row_o = {idx_i[IDXW-1:1], 1'b0};
      end else if (wide_i) begin
        sel_o = SEL_LO;
      end else begin
        // narrow mode: odd numbers alias the upper half of the pair
        row_o = {idx_i[IDXW-1:1], 1'b0};
        sel_o = idx_i[0] ? SEL_HI : SEL_LO;
      end
    end
  end
endmodule

// File: rtl/fpr_bank.sv
module fpr_bank
  import fpr_pkg::*;
#(
  parameter int unsigned NREG = 32,
  parameter int unsigned XLEN = 64,
  localparam int unsigned IDXW = $clog2(NREG),
  localparam int unsigned HLEN = XLEN / 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IDXW-1:0] wrow_i,
  input  half_sel_e       wsel_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [IDXW-1:0] rrow_i,
  output logic [XLEN-1:0] rdata_o
);
  logic [XLEN-1:0] mem [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_row
    logic [XLEN-1:0] row_q;
    logic            hit;
    assign hit = (wrow_i == IDXW'(r));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        row_q <= '0;
      end else if (hit) begin
        if (wsel_i == SEL_BOTH) begin
          row_q <= wdata_i;
        end else if (wsel_i == SEL_LO) begin
          row_q[HLEN-1:0] <= wdata_i[HLEN-1:0];
        end else if (wsel_i == SEL_HI) begin
          row_q[XLEN-1:HLEN] <= wdata_i[HLEN-1:0];
        end
      end
    end
    assign mem[r] = row_q;
  end

  assign rdata_o = mem[rrow_i];
endmodule

// File: rtl/fpr_rd_fmt.sv
module fpr_rd_fmt
  import fpr_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  localparam int unsigned HLEN = XLEN / 2
) (
  input  logic [XLEN-1:0] row_i,
  input  half_sel_e       sel_i,
  output logic [XLEN-1:0] data_o
);
  always_comb begin
    unique case (sel_i)
      SEL_BOTH: data_o = row_i;
      SEL_LO:   data_o = {{HLEN{1'b0}}, row_i[HLEN-1:0]};
      SEL_HI:   data_o = {{HLEN{1'b0}}, row_i[XLEN-1:HLEN]};
      default:  data_o = '0;
    endcase
  end
endmodule

// File: rtl/fpr_file.sv
module fpr_file
  import fpr_pkg::*;
#(
  parameter int unsigned NREG = 32,
  parameter int unsigned XLEN = 64,
  localparam int unsigned IDXW = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wide_i,
  input  logic            cu_ok_i,
  input  logic            rd_en_i,
  input  logic [IDXW-1:0] rd_idx_i,
  input  logic            rd_dbl_i,
  output logic [XLEN-1:0] rd_data_o,
  input  logic            wr_en_i,
  input  logic [IDXW-1:0] wr_idx_i,
  input  logic            wr_dbl_i,
  input  logic [XLEN-1:0] wr_data_i,
  output logic            cu_fault_o,
  output logic [1:0]      cu_num_o
);
  logic            rd_act, wr_act;
  logic [IDXW-1:0] rd_row, wr_row;
  half_sel_e       rd_sel, wr_sel;
  logic [XLEN-1:0] rd_row_data;

  assign rd_act = rd_en_i & cu_ok_i;
  assign wr_act = wr_en_i & cu_ok_i;

  fpr_addr_map #(.IDXW(IDXW)) u_rd_map (
    .idx_i (rd_idx_i), .dbl_i (rd_dbl_i), .wide_i (wide_i), .act_i (rd_act),
    .row_o (rd_row),   .sel_o (rd_sel)
  );

  fpr_addr_map #(.IDXW(IDXW)) u_wr_map (
    .idx_i (wr_idx_i), .dbl_i (wr_dbl_i), .wide_i (wide_i), .act_i (wr_act),
    .row_o (wr_row),   .sel_o (wr_sel)
  );

  fpr_bank #(.NREG(NREG), .XLEN(XLEN)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wrow_i  (wr_row),
    .wsel_i  (wr_sel),
    .wdata_i (wr_data_i),
    .rrow_i  (rd_row),
    .rdata_o (rd_row_data)
  );

  fpr_rd_fmt #(.XLEN(XLEN)) u_fmt (
    .row_i  (rd_row_data),
    .sel_i  (rd_sel),
    .data_o (rd_data_o)
  );

  assign cu_fault_o = (rd_en_i | wr_en_i) & ~cu_ok_i;
  assign cu_num_o   = cu_fault_o ? CU_NUM_FPU : 2'd0;
endmodule

// File: rtl/fpr_file_chk.sv
module fpr_file_chk #(
  parameter int unsigned NREG = 32,
  parameter int unsigned XLEN = 64,
  localparam int unsigned IDXW = $clog2(NREG)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wide_i,
  input logic            cu_ok_i,
  input logic            rd_en_i,
  input logic [IDXW-1:0] rd_idx_i,
  input logic            rd_dbl_i,
  input logic [XLEN-1:0] rd_data_o,
  input logic            wr_en_i,
  input logic            cu_fault_o,
  input logic [1:0]      cu_num_o
);
  a_r6_fault_raised: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_en_i || wr_en_i) && !cu_ok_i) |-> (cu_fault_o && cu_num_o == 2'd1));

  a_r6_read_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !cu_ok_i) |-> (rd_data_o == '0));

  a_r10_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cu_ok_i || (!rd_en_i && !wr_en_i)) |-> (!cu_fault_o && cu_num_o == 2'd0));

  a_r8_zero_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rd_dbl_i) |-> (rd_data_o[XLEN-1:XLEN/2] == '0));

  // R9: without a write, a repeated read sees the same value
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && cu_ok_i && $past(rd_en_i) && $past(cu_ok_i) && !$past(wr_en_i)
     && $stable(rd_idx_i) && $stable(rd_dbl_i) && $stable(wide_i))
    |-> $stable(rd_data_o));
endmodule

bind fpr_file fpr_file_chk #(.NREG(NREG), .XLEN(XLEN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wide_i     (wide_i),
  .cu_ok_i    (cu_ok_i),
  .rd_en_i    (rd_en_i),
  .rd_idx_i   (rd_idx_i),
  .rd_dbl_i   (rd_dbl_i),
  .rd_data_o  (rd_data_o),
  .wr_en_i    (wr_en_i),
  .cu_fault_o (cu_fault_o),
  .cu_num_o   (cu_num_o)
);

// File: tb/tb_fpr_file.sv
module tb_fpr_file;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wide_i = 1'b0, cu_ok_i = 1'b1;
  logic        rd_en_i = 1'b0, rd_dbl_i = 1'b0;
  logic [4:0]  rd_idx_i = '0;
  logic [63:0] rd_data_o;
  logic        wr_en_i = 1'b0, wr_dbl_i = 1'b0;
  logic [4:0]  wr_idx_i = '0;
  logic [63:0] wr_data_i = '0;
  logic        cu_fault_o;
  logic [1:0]  cu_num_o;

  int checks = 0, errors = 0;
  logic [63:0] model [32];

  fpr_file dut (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  function automatic logic [63:0] exp_read();
    logic [4:0] n;
    if (!rd_en_i || !cu_ok_i) return 64'd0;
    n = rd_idx_i;
    if (rd_dbl_i) return wide_i ? model[n] : model[{n[4:1], 1'b0}];
    if (wide_i || !n[0]) return {32'd0, model[n][31:0]};
    return {32'd0, model[n - 5'd1][63:32]};
  endfunction

  task automatic apply_write();
    logic [4:0] n;
    if (!wr_en_i || !cu_ok_i) return;
    n = wr_idx_i;
    if (wr_dbl_i) begin
      if (!wide_i) n[0] = 1'b0;
      model[n] = wr_data_i;
    end else if (wide_i || !n[0]) begin
      model[n][31:0] = wr_data_i[31:0];
    end else begin
      model[n - 5'd1][63:32] = wr_data_i[31:0];
    end
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive on the falling edge, check after settling, model follows the write
  task automatic cycle(input string tag,
                       input logic w, input logic ok,
                       input logic re, input logic [4:0] ri, input logic rdb,
                       input logic we, input logic [4:0] wi, input logic wdb,
                       input logic [63:0] wd);
    logic exp_f;
    @(negedge clk_i);
    wide_i = w; cu_ok_i = ok;
    rd_en_i = re; rd_idx_i = ri; rd_dbl_i = rdb;
    wr_en_i = we; wr_idx_i = wi; wr_dbl_i = wdb; wr_data_i = wd;
    #1;
    chk(tag, rd_data_o, exp_read());
    exp_f = (re || we) && !ok;
    chk(exp_f ? "R6 fault" : "R10 fault", {62'd0, cu_num_o}, exp_f ? 64'd1 : 64'd0);
    chk(exp_f ? "R6 flag" : "R10 flag", {63'd0, cu_fault_o}, {63'd0, exp_f});
    apply_write();
  endtask

  task automatic rd(input string tag, input logic w, input logic [4:0] i, input logic d);
    cycle(tag, w, 1'b1, 1'b1, i, d, 1'b0, 5'd0, 1'b0, 64'd0);
  endtask

  task automatic wr(input logic w, input logic [4:0] i, input logic d, input logic [63:0] v);
    cycle("R9 idle", w, 1'b1, 1'b0, 5'd0, 1'b0, 1'b1, i, d, v);
  endtask

  initial begin : watchdog
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 64'd0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: reset contents
    for (int i = 0; i < 32; i++) rd("R1", 1'b1, 5'(i), 1'b1);

    // R3: narrow odd write lands in upper half of pair
    wr(1'b0, 5'd3, 1'b0, 64'hFFFF_FFFF_AAAA_0003);
    rd("R3", 1'b1, 5'd2, 1'b1);
    rd("R3", 1'b1, 5'd3, 1'b1);
    rd("R3", 1'b0, 5'd3, 1'b0);
    // R4, R7: even write keeps the other half
    wr(1'b0, 5'd2, 1'b0, 64'h1111_1111_BBBB_0002);
    rd("R7", 1'b1, 5'd2, 1'b1);
    rd("R4", 1'b0, 5'd2, 1'b0);
    // R2: wide single to odd index
    wr(1'b1, 5'd7, 1'b0, 64'h2222_2222_CCCC_0007);
    rd("R2", 1'b1, 5'd7, 1'b1);
    rd("R2", 1'b1, 5'd6, 1'b1);
    // R5: double to odd index in both modes
    wr(1'b0, 5'd9, 1'b1, 64'hDEAD_BEEF_0123_4567);
    rd("R5", 1'b1, 5'd8, 1'b1);
    rd("R5", 1'b1, 5'd9, 1'b1);
    wr(1'b1, 5'd9, 1'b1, 64'h0BAD_F00D_89AB_CDEF);
    rd("R5", 1'b0, 5'd9, 1'b1);
    rd("R5", 1'b1, 5'd9, 1'b1);
    // R8: single read of a full entry
    rd("R8", 1'b1, 5'd9, 1'b0);
    // R9: same-cycle read and write of one entry sees old value, then new
    cycle("R9", 1'b1, 1'b1, 1'b1, 5'd9, 1'b1, 1'b1, 5'd9, 1'b1, 64'h5555_6666_7777_8888);
    rd("R9", 1'b1, 5'd9, 1'b1);
    // R6: unusable write has no effect, read blanked
    cycle("R6", 1'b1, 1'b0, 1'b1, 5'd9, 1'b1, 1'b1, 5'd9, 1'b1, 64'h0);
    rd("R6", 1'b1, 5'd9, 1'b1);
    cycle("R6", 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b1, 5'd3, 1'b0, 64'h0);
    rd("R6", 1'b1, 5'd2, 1'b1);
    // R10: no request, no fault
    cycle("R10", 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 64'h0);

    // random mix
    for (int k = 0; k < 4000; k++) begin
      logic w, ok, re, rdb, we, wdb;
      logic [4:0] ri, wi;
      logic [63:0] wd;
      string tag;
      w   = 1'($urandom);
      ok  = ($urandom_range(0, 9) != 0);
      re  = ($urandom_range(0, 3) != 0);
      we  = 1'($urandom);
      rdb = 1'($urandom);
      wdb = 1'($urandom);
      ri  = 5'($urandom);
      wi  = ($urandom_range(0, 3) == 0) ? ri : 5'($urandom);
      wd  = {$urandom, $urandom};
      if (!ok) tag = "R6 rand";
      else if (rdb) tag = "R5 rand";
      else if (w) tag = "R2 rand";
      else if (ri[0]) tag = "R3 rand";
      else tag = "R4 rand";
      cycle(tag, w, ok, re, ri, rdb, we, wi, wdb, wd);
    end

    // final sweep of all entries
    for (int i = 0; i < 32; i++) rd("R7 sweep", 1'b1, 5'(i), 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule